// File: doc/BRIEF.md
# Three-Axis Sample Buffer with Selectable Fill Policy

This block stores angular-rate samples for a host that reads them in bursts. Each sample is a set of three 16-bit channel values (X, Y and Z). The three values are written together as one entry when a new sample is ready. They are read out together into three output registers when the host pops. The buffer holds 32 entries. Software picks one of three fill policies with a configuration write:

- a single-slot pass-through, where only the latest sample is kept;
- a capture that halts once the buffer is full;
- a stream that discards the oldest entry when the buffer is full.

A 5-bit watermark, empty and full flags, a sticky overrun flag and a 5-bit count of unread entries give the host what it needs to size its reads. An interrupt output combines the watermark, full and empty conditions, each behind its own enable bit. The only way to restart a capture that has halted is to write the pass-through policy, which clears every pointer.

Top module: `tri_axis_sample_fifo`

## Requirements
- R1: The buffer holds 32 entries. A push stores `smp_x_i`, `smp_y_i` and `smp_z_i` as one entry. Each accepted pop loads the oldest stored entry into `rd_x_o`, `rd_y_o` and `rd_z_o`, which change on the clock edge that samples the pop. Entries leave in the order they arrived.
- R2: A write on `cfg_wr_i` selects the policy from `cfg_mode_i` and the watermark from `cfg_wm_i`. The policy codes are: 2'b00 pass-through, 2'b01 halt-on-full, 2'b10 stream, and 2'b11 behaves as pass-through. After reset the policy is pass-through, the watermark is 0, all flags except empty are low, and the data outputs are zero.
- R3: In pass-through, each push overwrites the single slot. A pop loads the slot's current contents; when a push and a pop share a cycle, the pop sees the value from before the push. In this policy `empty_o` is 1 and `level_o` is 0.
- R4: In halt-on-full, a push that arrives while 32 entries are stored is dropped, and the stored contents stay unchanged. Writing halt-on-full or stream does not restart the buffer; only writing pass-through does.
- R5: In stream, a push that arrives while the buffer is full and no pop is accepted removes the oldest entry and appends the new one. The level stays at 32.
- R6: A configuration write selecting pass-through clears the level, both pointers and the overrun flag. A push or pop in a cycle that carries `cfg_wr_i` is ignored.
- R7: `ovr_o` becomes 1 when a push arrives at a full buffer, with no pop accepted, in halt-on-full or stream. It stays 1 until the next configuration write that selects pass-through.
- R8: When a push and a pop arrive in the same cycle, the pop is served first. A full halt-on-full buffer therefore accepts the push, and the level does not change.
- R9: A pop while no entry is stored, outside pass-through, leaves the data outputs and the level unchanged.
- R10: `wm_o` is 1 when the policy is not pass-through and the stored level is greater than or equal to the programmed watermark.
- R11: `level_o` is the low 5 bits of the stored level, so it reads 0 when 32 entries are stored. `full_o` is 1 at 32 entries and `empty_o` is 1 at 0 entries.
- R12: `irq_o` is the OR of the enabled conditions: `irq_en_i[0]` enables watermark, `irq_en_i[1]` enables full, and `irq_en_i[2]` enables empty. The output is combinational from the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_mode_i | input | 2 | Fill policy code |
| cfg_wm_i | input | 5 | Watermark level |
| irq_en_i | input | 3 | Interrupt enables: [0] watermark, [1] full, [2] empty |
| push_i | input | 1 | New sample ready |
| smp_x_i | input | 16 | X channel sample |
| smp_y_i | input | 16 | Y channel sample |
| smp_z_i | input | 16 | Z channel sample |
| pop_i | input | 1 | Host read of the output registers |
| rd_x_o | output | 16 | X output register |
| rd_y_o | output | 16 | Y output register |
| rd_z_o | output | 16 | Z output register |
| level_o | output | 5 | Unread entry count, low 5 bits |
| empty_o | output | 1 | No entry stored |
| full_o | output | 1 | 32 entries stored |
| wm_o | output | 1 | Watermark reached |
| ovr_o | output | 1 | Sticky overrun |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench fills the halt-on-full buffer past 32 entries and then drains it. A design that let the write pointer advance on a dropped push would return a late sample in place of an early one. In stream policy it pushes 40 samples and expects exactly the last 32 back. A design that moved only the write pointer on overflow would replay stale data. A push and a pop on a full halt-on-full buffer in the same cycle must be accepted, so a design that judged room before the read would silently lose that sample. Popping an empty buffer, a push landing in the same cycle as a configuration write, and the 2'b11 policy code are also probed. Any of these gives a wrong level, a moved output register or an overrun flag that is not cleared.

// File: rtl/tsf_pkg.sv
package tsf_pkg;

  localparam int unsigned CH_N = 3;

  typedef enum logic [1:0] {
    MD_BYPASS = 2'b00,
    MD_HALT   = 2'b01,
    MD_STREAM = 2'b10,
    MD_RSVD   = 2'b11
  } fill_mode_e;

  // the unused code falls back to pass-through
  function automatic fill_mode_e decode_mode(input logic [1:0] code);
    fill_mode_e m;
    m = fill_mode_e'(code);
    return (m == MD_RSVD) ? MD_BYPASS : m;
  endfunction

endpackage

// File: rtl/tsf_ptr_ctrl.sv
module tsf_ptr_ctrl
  import tsf_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr_i,
  input  fill_mode_e    cfg_mode_i,
  input  logic          push_i,
  input  logic          pop_i,
  output fill_mode_e    mode_o,
  output logic [AW:0]   level_o,
  output logic          ovr_o,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic          rd_en_o,
  output logic [AW-1:0] rd_addr_o
);

  localparam logic [AW:0] LVL_FULL = (AW+1)'(DEPTH);

  function automatic logic [AW-1:0] ptr_step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // a slot is free if not full, or if the read in this cycle frees one
  function automatic logic has_room(input logic [AW:0] lvl, input logic freed);
    return (lvl != LVL_FULL) || freed;
  endfunction

  function automatic logic [AW:0] lvl_next(input logic [AW:0] lvl,
                                           input logic inc, input logic dec);
    return lvl + {{AW{1'b0}}, inc} - {{AW{1'b0}}, dec};
  endfunction

  fill_mode_e    mode_q;
  logic [AW-1:0] wr_q, rd_q;
  logic [AW:0]   lvl_q;
  logic          ovr_q;

  // named internal events
  logic is_byp, live, pop_ok, room, push_ok, overwrite, push_drop, byp_write;

  assign is_byp    = (mode_q == MD_BYPASS);
  assign live      = !cfg_wr_i;
  assign pop_ok    = live && pop_i && !is_byp && (lvl_q != '0);
  assign room      = has_room(lvl_q, pop_ok);
  assign push_ok   = live && push_i && !is_byp && room;
  assign overwrite = live && push_i && (mode_q == MD_STREAM) && !room;
  assign push_drop = live && push_i && (mode_q == MD_HALT) && !room;
  assign byp_write = live && push_i && is_byp;

  assign wr_en_o   = byp_write || push_ok || overwrite;
  assign wr_addr_o = is_byp ? '0 : wr_q;
  assign rd_en_o   = pop_ok || (live && pop_i && is_byp);
  assign rd_addr_o = is_byp ? '0 : rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MD_BYPASS;
      wr_q   <= '0;
      rd_q   <= '0;
      lvl_q  <= '0;
      ovr_q  <= 1'b0;
    end else if (cfg_wr_i) begin
      mode_q <= cfg_mode_i;
      if (cfg_mode_i == MD_BYPASS) begin
        wr_q  <= '0;
        rd_q  <= '0;
        lvl_q <= '0;
        ovr_q <= 1'b0;
      end
    end else begin
      if (push_ok || overwrite) wr_q <= ptr_step(wr_q);
      if (pop_ok || overwrite)  rd_q <= ptr_step(rd_q);
      lvl_q <= lvl_next(lvl_q, push_ok, pop_ok);
      if (overwrite || push_drop) ovr_q <= 1'b1;
    end
  end

  assign mode_o  = mode_q;
  assign level_o = lvl_q;
  assign ovr_o   = ovr_q;

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= LVL_FULL);  // R1

  AST_BYPASS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_i && cfg_mode_i == MD_BYPASS |=> lvl_q == '0 && !ovr_q);  // R6

  AST_HALT_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q == MD_HALT && lvl_q == LVL_FULL && push_i && !pop_i && !cfg_wr_i
    |=> lvl_q == LVL_FULL && $stable(wr_q) && ovr_q);  // R4

  AST_STREAM_SLIDE: assert property (@(posedge clk) disable iff (!rst_n)
    overwrite |=> lvl_q == LVL_FULL && ovr_q && rd_q == wr_q);  // R5

  AST_SAME_CYCLE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q == MD_HALT && lvl_q == LVL_FULL && push_i && pop_i && !cfg_wr_i
    |=> lvl_q == LVL_FULL);  // R8

  AST_EMPTY_POP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !is_byp && lvl_q == '0 && pop_i && !push_i && !cfg_wr_i
    |=> lvl_q == '0);  // R9

endmodule

// File: rtl/tsf_store.sv
module tsf_store #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned DW    = 16,
  parameter int unsigned CH    = 3,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en_i,
  input  logic [AW-1:0]          wr_addr_i,
  input  logic [CH-1:0][DW-1:0]  wr_data_i,
  input  logic                   rd_en_i,
  input  logic [AW-1:0]          rd_addr_i,
  output logic [CH-1:0][DW-1:0]  rd_data_o
);

  logic [CH-1:0][DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en_i) mem[wr_addr_i] <= wr_data_i;
  end

  // one output register per channel; the read sees the slot before any same-cycle write
  for (genvar c = 0; c < CH; c++) begin : g_chan
    logic [DW-1:0] out_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       out_q <= '0;
      else if (rd_en_i) out_q <= mem[rd_addr_i][c];
    end
    assign rd_data_o[c] = out_q;
  end

endmodule

// File: rtl/tsf_flags.sv
module tsf_flags #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW:0]   level_i,
  input  logic          bypass_i,
  input  logic [AW-1:0] wm_i,
  input  logic [2:0]    irq_en_i,
  output logic [AW-1:0] count_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          wm_o,
  output logic          irq_o
);

  function automatic logic wm_reached(input logic [AW:0] lvl, input logic [AW-1:0] wm);
    return lvl >= {1'b0, wm};
  endfunction

  assign count_o = level_i[AW-1:0];
  assign empty_o = (level_i == '0);
  assign full_o  = (level_i == (AW+1)'(DEPTH));
  assign wm_o    = !bypass_i && wm_reached(level_i, wm_i);
  assign irq_o   = (irq_en_i[0] && wm_o) || (irq_en_i[1] && full_o) ||
                   (irq_en_i[2] && empty_o);

  AST_BYPASS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_i |-> empty_o && !wm_o && count_o == '0);  // R3

  AST_WM_AT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    full_o && !bypass_i |-> wm_o);  // R10

endmodule

// File: rtl/tri_axis_sample_fifo.sv
module tri_axis_sample_fifo
  import tsf_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned DW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr_i,
  input  logic [1:0]    cfg_mode_i,
  input  logic [4:0]    cfg_wm_i,
  input  logic [2:0]    irq_en_i,
  input  logic          push_i,
  input  logic [DW-1:0] smp_x_i,
  input  logic [DW-1:0] smp_y_i,
  input  logic [DW-1:0] smp_z_i,
  input  logic          pop_i,
  output logic [DW-1:0] rd_x_o,
  output logic [DW-1:0] rd_y_o,
  output logic [DW-1:0] rd_z_o,
  output logic [4:0]    level_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          wm_o,
  output logic          ovr_o,
  output logic          irq_o
);

  localparam int unsigned AW = $clog2(DEPTH);

  fill_mode_e              mode;
  logic [AW:0]             level;
  logic [AW-1:0]           wm_q;
  logic                    wr_en, rd_en;
  logic [AW-1:0]           wr_addr, rd_addr;
  logic [CH_N-1:0][DW-1:0] wr_data, rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wm_q <= '0;
    else if (cfg_wr_i) wm_q <= AW'(cfg_wm_i);
  end

  assign wr_data[0] = smp_x_i;
  assign wr_data[1] = smp_y_i;
  assign wr_data[2] = smp_z_i;

  tsf_ptr_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr_i  (cfg_wr_i),
    .cfg_mode_i(decode_mode(cfg_mode_i)),
    .push_i    (push_i),
    .pop_i     (pop_i),
    .mode_o    (mode),
    .level_o   (level),
    .ovr_o     (ovr_o),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .rd_en_o   (rd_en),
    .rd_addr_o (rd_addr)
  );

  tsf_store #(.DEPTH(DEPTH), .DW(DW), .CH(CH_N), .AW(AW)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en_i  (wr_en),
    .wr_addr_i(wr_addr),
    .wr_data_i(wr_data),
    .rd_en_i  (rd_en),
    .rd_addr_i(rd_addr),
    .rd_data_o(rd_data)
  );

  tsf_flags #(.DEPTH(DEPTH), .AW(AW)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (level),
    .bypass_i(mode == MD_BYPASS),
    .wm_i    (wm_q),
    .irq_en_i(irq_en_i),
    .count_o (level_o),
    .empty_o (empty_o),
    .full_o  (full_o),
    .wm_o    (wm_o),
    .irq_o   (irq_o)
  );

  assign rd_x_o = rd_data[0];
  assign rd_y_o = rd_data[1];
  assign rd_z_o = rd_data[2];

  AST_EMPTY_POP_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i && empty_o && mode != MD_BYPASS && !cfg_wr_i
    |=> $stable(rd_x_o) && $stable(rd_y_o) && $stable(rd_z_o));  // R9

  AST_CFG_CYCLE_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_i && push_i && decode_mode(cfg_mode_i) != MD_BYPASS
    |=> $stable(level));  // R6

  AST_NO_POP_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pop_i |=> $stable(rd_x_o) && $stable(rd_y_o) && $stable(rd_z_o));  // R1

endmodule

// File: tb/tb_tri_axis_sample_fifo.sv
module tb_tri_axis_sample_fifo;

  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_i = 1'b0;
  logic [1:0]  cfg_mode_i = '0;
  logic [4:0]  cfg_wm_i = '0;
  logic [2:0]  irq_en_i = '0;
  logic        push_i = 1'b0;
  logic [15:0] smp_x_i = '0, smp_y_i = '0, smp_z_i = '0;
  logic        pop_i = 1'b0;
  logic [15:0] rd_x_o, rd_y_o, rd_z_o;
  logic [4:0]  level_o;
  logic        empty_o, full_o, wm_o, ovr_o, irq_o;

  always #(CLK_NS/2) clk = ~clk;

  tri_axis_sample_fifo dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_i(cfg_wr_i), .cfg_mode_i(cfg_mode_i),
    .cfg_wm_i(cfg_wm_i), .irq_en_i(irq_en_i), .push_i(push_i),
    .smp_x_i(smp_x_i), .smp_y_i(smp_y_i), .smp_z_i(smp_z_i), .pop_i(pop_i),
    .rd_x_o(rd_x_o), .rd_y_o(rd_y_o), .rd_z_o(rd_z_o), .level_o(level_o),
    .empty_o(empty_o), .full_o(full_o), .wm_o(wm_o), .ovr_o(ovr_o), .irq_o(irq_o)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;
  string cur_tag = "R1";
  int seq = 0;

  // reference model
  logic [47:0] mq[$];
  logic [47:0] exp_q[$];
  int          m_mode = 0;
  bit          m_ovr = 0;
  int          m_wm = 0;
  logic [47:0] bsl = '0;
  logic [47:0] last = '0;

  function automatic logic [47:0] mk(input int n);
    return {16'h1000 + 16'(n), 16'h2000 + 16'(n * 3), 16'hC000 ^ 16'(n * 7)};
  endfunction

  task automatic chk(input string what, input logic [47:0] a, input logic [47:0] e);
    total++;
    if (a !== e) begin
      bad++;
      $display("FAIL %s: got %h expected %h", what, a, e);
    end
  endtask

  // driver: updates the model and queues the expected pop result
  task automatic step(input bit pu, input bit po);
    logic [47:0] d;
    logic [47:0] e;
    seq++;
    d = mk(seq);
    @(negedge clk);
    if (m_mode == 0) begin
      if (po) begin e = bsl; last = e; exp_q.push_back(e); end
      if (pu) bsl = d;
    end else begin
      if (po) begin
        if (mq.size() > 0) e = mq.pop_front();
        else e = last;
        last = e;
        exp_q.push_back(e);
      end
      if (pu) begin
        if (mq.size() < 32) mq.push_back(d);
        else begin
          m_ovr = 1;
          if (m_mode == 2) begin void'(mq.pop_front()); mq.push_back(d); end
        end
      end
    end
    push_i = pu; pop_i = po;
    {smp_x_i, smp_y_i, smp_z_i} = d;
    @(posedge clk);
    #1;
    push_i = 0; pop_i = 0;
  endtask

  task automatic cfg(input logic [1:0] m, input int w, input bit pu);
    @(negedge clk);
    cfg_wr_i = 1; cfg_mode_i = m; cfg_wm_i = 5'(w); push_i = pu;
    m_mode = (m == 2'b11) ? 0 : int'(m);
    m_wm = w;
    if (m_mode == 0) begin mq.delete(); m_ovr = 0; end
    @(posedge clk);
    #1;
    cfg_wr_i = 0; push_i = 0;
  endtask

  task automatic status(input string t);
    int  n;
    bit  e_wm, e_full, e_empty, e_irq;
    @(negedge clk);
    n = mq.size();
    e_full  = (n == 32);
    e_empty = (n == 0);
    e_wm    = (m_mode != 0) && (n >= m_wm);
    e_irq   = (irq_en_i[0] && e_wm) || (irq_en_i[1] && e_full) || (irq_en_i[2] && e_empty);
    chk({t, " R11 count"}, 48'(level_o), 48'(n % 32));
    chk({t, " R11 full"},  48'(full_o),  48'(e_full));
    chk({t, " R11 empty"}, 48'(empty_o), 48'(e_empty));
    chk({t, " R10 wm"},    48'(wm_o),    48'(e_wm));
    chk({t, " R7 ovr"},    48'(ovr_o),   48'(m_ovr));
    chk({t, " R12 irq"},   48'(irq_o),   48'(e_irq));
  endtask

  // monitor: compares each popped result against the scoreboard queue
  always @(posedge clk) begin : mon
    logic [47:0] e;
    if (rst_n && pop_i && !cfg_wr_i) begin
      #(CLK_NS/4);
      if (exp_q.size() == 0) begin
        chk({cur_tag, " unexpected pop"}, 48'h1, 48'h0);
      end else begin
        e = exp_q.pop_front();
        chk({cur_tag, " R1 pop data"}, {rd_x_o, rd_y_o, rd_z_o}, e);
      end
    end
  end

  initial begin : watchdog
    #(CLK_NS * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired (R1..R12 run hung): got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R2: reset state
    cur_tag = "R2";
    status("R2 reset");
    chk("R2 reset outputs", {rd_x_o, rd_y_o, rd_z_o}, 48'h0);

    // R3: pass-through
    cur_tag = "R3";
    step(1, 0); step(1, 0);
    status("R3 bypass");
    step(0, 1);
    step(1, 1);
    step(0, 1);
    status("R3 bypass after pops");

    // R1 / R10: halt policy, ordering and watermark
    cur_tag = "R1";
    cfg(2'b01, 4, 0);
    for (int i = 0; i < 3; i++) step(1, 0);
    status("R10 below wm");
    for (int i = 0; i < 2; i++) step(1, 0);
    status("R10 at or above wm");
    step(0, 1); step(0, 1);
    status("R1 after two pops");

    // R4 / R7: fill past capacity in halt policy
    cur_tag = "R4";
    while (mq.size() < 32) step(1, 0);
    for (int i = 0; i < 3; i++) step(1, 0);
    status("R4 halted full");
    cfg(2'b10, 4, 0);
    status("R4 stream write keeps state");
    cfg(2'b01, 4, 0);
    for (int i = 0; i < 32; i++) step(0, 1);
    status("R4 drained");

    // R9: pop while empty
    cur_tag = "R9";
    step(0, 1);
    status("R9 empty pop");

    // R6: return to pass-through clears; cfg cycle ignores push
    cur_tag = "R6";
    cfg(2'b00, 4, 0);
    status("R6 cleared");
    cfg(2'b01, 2, 1);
    status("R6 push during cfg ignored");

    // R5: stream keeps the newest 32
    cur_tag = "R5";
    cfg(2'b00, 0, 0);
    cfg(2'b10, 0, 0);
    for (int i = 0; i < 40; i++) step(1, 0);
    status("R5 stream full");
    for (int i = 0; i < 32; i++) step(0, 1);
    status("R5 stream drained");

    // R8: push and pop together on a full halt buffer
    cur_tag = "R8";
    cfg(2'b00, 0, 0);
    cfg(2'b01, 31, 0);
    while (mq.size() < 32) step(1, 0);
    step(1, 1);
    status("R8 still full");
    for (int i = 0; i < 32; i++) step(0, 1);
    status("R8 drained");

    // R12: interrupt enables
    cur_tag = "R12";
    cfg(2'b00, 0, 0);
    cfg(2'b01, 8, 0);
    irq_en_i = 3'b100;
    status("R12 empty enabled");
    for (int i = 0; i < 3; i++) step(1, 0);
    status("R12 empty enabled not empty");
    irq_en_i = 3'b011;
    status("R12 wm/full enabled below");
    while (mq.size() < 32) step(1, 0);
    irq_en_i = 3'b010;
    status("R12 full enabled");
    irq_en_i = 3'b000;
    status("R12 none enabled");

    // R2: reserved code acts as pass-through
    cur_tag = "R2";
    cfg(2'b11, 3, 0);
    status("R2 code 11 as bypass");
    step(1, 0);
    step(0, 1);
    status("R2 code 11 after push");

    repeat (3) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule